// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage of a small programmable-logic fabric. It holds a row of identical output cells, ten by default. Each cell receives the OR-sum produced for it by the product-term array, an output-enable term of its own, and two control terms shared by the whole row. One shared term clears every cell register at once, without a clock. The other sets every register on the next rising clock edge.

A two-bit configuration field per cell selects the cell's behaviour. The mode bit chooses between a clocked path and a combinational path. The polarity bit chooses whether the pin shows the true value or its complement. Each cell drives a pin model made of a value and an enable. It also returns a feedback bit to the array. In clocked mode the feedback is the register state, which lets the array build state machines. In combinational mode the feedback is the level on the pin. When the cell drives the pin, that level is the cell's own output. When the cell does not drive the pin, it is the externally supplied value, so the pin works as an input.

The configuration bus is treated as static wiring. How it gets loaded is outside this block.

Top module: `macrocell_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, every cell register is cleared to 0. After reset, a clocked cell drives its pin at 0 when its polarity bit is 1 and at 1 when its polarity bit is 0, and its feedback bit reads 0.
- R2: A clocked cell (mode bit `cfg[2i+1]` = 0) captures `sum_in[i]` on the rising clock edge. Its pin value changes only after that edge, never as soon as the sum changes.
- R3: A combinational cell (mode bit = 1) presents `sum_in[i]` on its pin in the same cycle, with no clock edge involved.
- R4: The polarity bit `cfg[2i]` = 1 passes the cell value to the pin unchanged, and 0 inverts it. This holds in both modes, and the inversion sits after the register.
- R5: `pin_oe[i]` follows `oe_term[i]` for every cell in every mode, so a pin can be driven always, never, or under array control.
- R6: The feedback of a clocked cell is its register state. Neither `oe_term` nor `pin_in` affects it.
- R7: The feedback of a combinational cell equals `pin_out[i]` while the cell is enabled and `pin_in[i]` while it is disabled.
- R8: While `ar_term` is high, every register reads 0 at once, without waiting for a clock edge, and it stays 0 across clock edges.
- R9: When `sp_term` is high at a rising edge, every register becomes 1, whatever the OR-sums are.
- R10: When `ar_term` and `sp_term` are high together, the clear wins and the registers stay 0.
- R11: Each cell follows only its own two configuration bits, so a single bank can mix modes and polarities cell by cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for all cell registers |
| rst | input | 1 | Power-on reset, synchronous, active high, clears the registers |
| ar_term | input | 1 | Shared asynchronous clear term, active high |
| sp_term | input | 1 | Shared synchronous preset term, active high |
| cfg | input | 2*N_CELLS | Per-cell configuration: bit 2i+1 is the mode (0 clocked, 1 combinational) and bit 2i is the polarity (1 true, 0 inverted) |
| sum_in | input | N_CELLS | OR-sum from the array, one bit per cell |
| oe_term | input | N_CELLS | Output-enable term, one bit per cell |
| pin_in | input | N_CELLS | Level placed on each pin by the outside when the pin is not driven |
| pin_out | output | N_CELLS | Value driven on each pin, after polarity |
| pin_oe | output | N_CELLS | Drive enable of each pin |
| fb | output | N_CELLS | Feedback from each cell to the array |

## Verification
The bench targets the places where the two modes behave differently. If a clocked cell leaked its sum straight to the pin, the pin would change before the edge. If a combinational cell took its feedback from the register or from the driven value, the feedback would not follow `pin_in` on a disabled pin. The bench also checks that the polarity inversion sits after the register: if it were applied before, a preset cell in inverted polarity would show 1 instead of 0. It raises the clear between clock edges, where a clear that waited for the clock would still show the old state. It also raises the clear and the preset together, where the wrong priority leaves the registers at 1. A last pattern mixes modes and polarities across neighbouring cells to expose swapped or shared configuration bits.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned CFG_BITS = 2;

  // bit 1: mode (0 clocked, 1 combinational); bit 0: polarity (1 true, 0 inverted)
  typedef struct packed {
    logic comb_mode;
    logic act_high;
  } cell_cfg_t;
endpackage

// File: rtl/mc_cell_reg.sv
module mc_cell_reg (
  input  logic clk,
  input  logic rst,
  input  logic ar_clr,
  input  logic sp_set,
  input  logic d,
  output logic q
);
  // Asynchronous clear has top priority, then power-on reset, then preset.
  always_ff @(posedge clk or posedge ar_clr) begin
    if (ar_clr)      q <= 1'b0;
    else if (rst)    q <= 1'b0;
    else if (sp_set) q <= 1'b1;
    else             q <= d;
  end
endmodule

// File: rtl/mc_cell_out.sv
module mc_cell_out
  import mc_pkg::*;
(
  input  cell_cfg_t cfg,
  input  logic      sum,
  input  logic      q,
  input  logic      oe,
  input  logic      pin_in,
  output logic      pin_out,
  output logic      pin_oe,
  output logic      fb
);
  logic core_val;
  logic pin_level;

  always_comb begin
    core_val  = cfg.comb_mode ? sum : q;
    pin_out   = cfg.act_high ? core_val : ~core_val;
    pin_oe    = oe;
    pin_level = oe ? pin_out : pin_in;
    fb        = cfg.comb_mode ? pin_level : q;
  end
endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ar_clr,
  input  logic      sp_set,
  input  cell_cfg_t cfg,
  input  logic      sum,
  input  logic      oe,
  input  logic      pin_in,
  output logic      pin_out,
  output logic      pin_oe,
  output logic      fb
);
  logic q;

  mc_cell_reg u_reg (
    .clk    (clk),
    .rst    (rst),
    .ar_clr (ar_clr),
    .sp_set (sp_set),
    .d      (sum),
    .q      (q)
  );

  mc_cell_out u_out (
    .cfg     (cfg),
    .sum     (sum),
    .q       (q),
    .oe      (oe),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .fb      (fb)
  );
endmodule

// File: rtl/macrocell_bank.sv
module macrocell_bank
  import mc_pkg::*;
#(
  parameter int unsigned N_CELLS = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ar_term,
  input  logic                          sp_term,
  input  logic [CFG_BITS*N_CELLS-1:0]   cfg,
  input  logic [N_CELLS-1:0]            sum_in,
  input  logic [N_CELLS-1:0]            oe_term,
  input  logic [N_CELLS-1:0]            pin_in,
  output logic [N_CELLS-1:0]            pin_out,
  output logic [N_CELLS-1:0]            pin_oe,
  output logic [N_CELLS-1:0]            fb
);
  localparam int unsigned CFG_W = CFG_BITS * N_CELLS;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    cell_cfg_t cell_cfg;
    assign cell_cfg = cell_cfg_t'(cfg[CFG_BITS*i +: CFG_BITS]);

    mc_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .ar_clr  (ar_term),
      .sp_set  (sp_term),
      .cfg     (cell_cfg),
      .sum     (sum_in[i]),
      .oe      (oe_term[i]),
      .pin_in  (pin_in[i]),
      .pin_out (pin_out[i]),
      .pin_oe  (pin_oe[i]),
      .fb      (fb[i])
    );
  end

  if (CFG_W != CFG_BITS * N_CELLS) begin : g_bad_width
    initial $error("configuration width mismatch");
  end
endmodule

// File: rtl/macrocell_bank_chk.sv
module macrocell_bank_chk #(
  parameter int unsigned N_CELLS = 10
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ar_term,
  input logic                   sp_term,
  input logic [2*N_CELLS-1:0]   cfg,
  input logic [N_CELLS-1:0]     sum_in,
  input logic [N_CELLS-1:0]     oe_term,
  input logic [N_CELLS-1:0]     pin_in,
  input logic [N_CELLS-1:0]     pin_out,
  input logic [N_CELLS-1:0]     pin_oe,
  input logic [N_CELLS-1:0]     fb
);
  logic [N_CELLS-1:0] comb_v;
  logic [N_CELLS-1:0] pol_v;
  logic [N_CELLS-1:0] level_v;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_dec
    assign comb_v[i] = cfg[2*i+1];
    assign pol_v[i]  = cfg[2*i];
  end
  assign level_v = (pin_oe & pin_out) | (~pin_oe & pin_in);

  // R1: reset clears clocked-cell feedback on the following cycle
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (ar_term || cfg != $past(cfg) || (fb & ~comb_v) == '0));

  // R2: clocked cells hold the sum sampled at the previous edge
  assert_capture_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (!ar_term && !sp_term) |=>
      (ar_term || cfg != $past(cfg) || ((fb ^ $past(sum_in)) & ~comb_v) == '0));

  // R3 and R4: combinational pins follow the sum through the polarity choice
  assert_comb_polarity_R4: assert property (@(posedge clk) disable iff (rst)
    ((pin_out ^ sum_in ^ ~pol_v) & comb_v) == '0);

  // R7: combinational feedback reflects the pin level
  assert_comb_feedback_R7: assert property (@(posedge clk) disable iff (rst)
    ((fb ^ level_v) & comb_v) == '0);

  // R8: an active clear keeps every register at zero
  assert_async_clear_R8: assert property (@(posedge clk) disable iff (rst)
    ar_term |-> (fb & ~comb_v) == '0);

  // R9: preset sets every register on the next edge
  assert_preset_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (sp_term && !ar_term) |=>
      (ar_term || cfg != $past(cfg) || (fb | comb_v) == '1));
endmodule

bind macrocell_bank macrocell_bank_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ar_term (ar_term),
  .sp_term (sp_term),
  .cfg     (cfg),
  .sum_in  (sum_in),
  .oe_term (oe_term),
  .pin_in  (pin_in),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .fb      (fb)
);

// File: tb/test_macrocell_bank.sv
module test_macrocell_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ar_term = 1'b0;
  logic           sp_term = 1'b0;
  logic [2*N-1:0] cfg = '0;
  logic [N-1:0]   sum_in = '0;
  logic [N-1:0]   oe_term = '0;
  logic [N-1:0]   pin_in = '0;
  logic [N-1:0]   pin_out;
  logic [N-1:0]   pin_oe;
  logic [N-1:0]   fb;

  int n_cmp = 0;
  int n_bad = 0;
  logic [N-1:0] qm = '0;   // expected register contents

  always #(CLK_PERIOD/2) clk = ~clk;

  macrocell_bank #(.N_CELLS(N)) i_macrocell_bank (
    .clk(clk), .rst(rst), .ar_term(ar_term), .sp_term(sp_term), .cfg(cfg),
    .sum_in(sum_in), .oe_term(oe_term), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  function automatic logic [2*N-1:0] mk_cfg(input logic [N-1:0] comb, input logic [N-1:0] pol);
    logic [2*N-1:0] r;
    for (int i = 0; i < N; i++) begin
      r[2*i+1] = comb[i];
      r[2*i]   = pol[i];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_pin(input logic [N-1:0] q, input logic [N-1:0] s,
                                           input logic [2*N-1:0] c);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      logic v;
      v = c[2*i+1] ? s[i] : q[i];
      r[i] = c[2*i] ? v : ~v;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_fb(input logic [N-1:0] q, input logic [N-1:0] s,
                                          input logic [2*N-1:0] c, input logic [N-1:0] oe,
                                          input logic [N-1:0] pi);
    logic [N-1:0] p;
    logic [N-1:0] r;
    p = exp_pin(q, s, c);
    for (int i = 0; i < N; i++)
      r[i] = !c[2*i+1] ? q[i] : (oe[i] ? p[i] : pi[i]);
    return r;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One clock edge; expected register updated from the inputs seen at the edge.
  task automatic tick();
    @(posedge clk);
    if (ar_term)      qm = '0;
    else if (rst)     qm = '0;
    else if (sp_term) qm = '1;
    else              qm = sum_in;
    #1;
  endtask

  task automatic chk_all(input string req);
    chk({req, " pin_out"}, pin_out, exp_pin(qm, sum_in, cfg));
    chk({req, " fb"}, fb, exp_fb(qm, sum_in, cfg, oe_term, pin_in));
    chk({req, " pin_oe"}, pin_oe, oe_term);
  endtask

  task automatic t_reset();
    cfg = mk_cfg('0, 10'b1010110010);
    sum_in = '1; oe_term = '1; rst = 1'b1;
    tick(); tick();
    rst = 1'b0; sum_in = '0; #1;
    chk("R1 reset pins", pin_out, ~10'b1010110010);
    chk("R1 reset fb", fb, '0);
  endtask

  task automatic t_registered();
    cfg = mk_cfg('0, '1); oe_term = '1;
    tick();
    sum_in = 10'b1100101001; #1;
    chk("R2 no change before edge", pin_out, '0);
    tick();
    chk("R2 captured", pin_out, 10'b1100101001);
    chk("R2 fb", fb, 10'b1100101001);
    oe_term = 10'b0101010101; pin_in = 10'b0011110000; sum_in = 10'b0110011001; #1;
    chk("R6 fb ignores oe and pin_in", fb, 10'b1100101001);
    chk("R5 oe passes", pin_oe, 10'b0101010101);
    tick();
    chk_all("R6 second pattern");
  endtask

  task automatic t_polarity();
    cfg = mk_cfg('0, '0); oe_term = '1; sum_in = 10'b1111000011;
    tick();
    chk("R4 clocked inverted", pin_out, 10'b0000111100);
    chk("R4 clocked fb stays true", fb, 10'b1111000011);
    cfg = mk_cfg('1, '0); #1;
    chk("R4 comb inverted", pin_out, 10'b0000111100);
    cfg = mk_cfg('1, '1); #1;
    chk("R4 comb true", pin_out, 10'b1111000011);
  endtask

  task automatic t_comb();
    cfg = mk_cfg('1, '1); oe_term = '1;
    sum_in = 10'b1010011100; #1;
    chk("R3 comb immediate", pin_out, 10'b1010011100);
    chk("R7 comb fb driven", fb, 10'b1010011100);
    sum_in = 10'b0101100011; #1;
    chk("R3 comb follows", pin_out, 10'b0101100011);
    oe_term = '0; pin_in = 10'b1110001110; #1;
    chk("R7 comb fb from pin", fb, 10'b1110001110);
    chk("R5 oe off", pin_oe, '0);
    oe_term = 10'b1111100000; #1;
    chk_all("R7 comb mixed enable");
    tick();
  endtask

  task automatic t_async();
    cfg = mk_cfg('0, 10'b0000011111); oe_term = '1; sum_in = '1;
    tick();
    chk("R8 preload", fb, '1);
    ar_term = 1'b1; #1;
    chk("R8 clear without edge", fb, '0);
    chk("R8 clear pins", pin_out, 10'b1111100000);
    tick();
    chk("R8 held over edge", fb, '0);
    ar_term = 1'b0; #1;
  endtask

  task automatic t_preset();
    cfg = mk_cfg('0, 10'b1111100000); sum_in = '0; sp_term = 1'b1;
    tick();
    sp_term = 1'b0; #1;
    chk("R9 preset fb", fb, '1);
    chk("R9 preset pins after polarity", pin_out, 10'b1111100000);
    tick();
    chk("R9 preset then sum", fb, '0);
  endtask

  task automatic t_conflict();
    cfg = mk_cfg('0, '1); sum_in = '1;
    tick();
    ar_term = 1'b1; sp_term = 1'b1; #1;
    tick();
    chk("R10 clear beats preset", fb, '0);
    chk("R10 pins", pin_out, '0);
    ar_term = 1'b0; sp_term = 1'b0; sum_in = '0; #1;
    tick();
  endtask

  task automatic t_mixed();
    cfg = mk_cfg(10'b1010101010, 10'b1001001001);
    oe_term = 10'b1100110011; pin_in = 10'b0110110110;
    sum_in = 10'b1011001110;
    tick();
    chk_all("R11 mixed cells A");
    sum_in = 10'b0100110001; #1;
    chk_all("R11 mixed cells B pre-edge");
    tick();
    chk_all("R11 mixed cells B post-edge");
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    #1;
    t_reset();
    t_registered();
    t_polarity();
    t_comb();
    t_async();
    t_preset();
    t_conflict();
    t_mixed();
    report();
  end
endmodule